// File: doc/BRIEF.md
# NAND Boot Image Loader

This block runs by itself at boot. It copies an image of a given byte length out of NAND flash into a destination memory, and it skips erase blocks that carry a bad-block mark. A companion flash operation engine does the actual flash transfers. The loader drives that engine one operation at a time: a command byte, an address byte, or a page transfer into its internal buffer. The loader then reads the engine's buffer through a one-cycle-latency read port and streams 32-bit words out through a plain write port.

Software sets the page size, the erase-block size, the image length and the destination base, then pulses `start`. The loader first resets the flash. For each erase block it reads the spare area and tests the mark. It reads good blocks page by page and stops after the page that uses up the requested length. It then raises `done` and holds it. A counter shows how many blocks were skipped.

Top module: `nand_boot_loader`

## Requirements
- R1: After reset, `done` is low, `op_req` and `dst_we` are low, and `bad_blocks` is 0.
- R2: The first operation after `start` is a command (op_kind 0) with byte 0xFF.
- R3: Every erase block begins with command byte 0x50, then four address cycles of the block's byte offset, then a transfer (op_kind 2) with `op_spare` high.
- R4: After that spare transfer the loader reads buffer word 1 of the spare area (`buf_spare`=1, `buf_word`=1). The block counts as good only if bits [7:0] of that word equal 0xFF, and the upper bits are ignored. A bad block gets no page operations and raises `bad_blocks` by one.
- R5: Each address group is four address operations (op_kind 1) carrying offset bits [7:0], [16:9], [24:17] and [31:25], in that order.
- R6: Each page of a good block takes command byte 0x00, four address cycles of the page offset (block offset plus page index times page size), and a transfer with `op_spare` low. An operation's kind, byte and spare flag stay stable while `op_req` waits for `op_done`.
- R7: After each page transfer the loader reads main buffer words 0 to 127 and writes each word k to address page_dest + 4k, with nothing else in between. page_dest starts at `dest_base` and grows by the page size (512, or 2048 when `page_large` is 1) after every page, even though only 512 bytes are copied.
- R8: Pages in a block run while the page index times the page size is less than the block size. The loader then moves on to the spare check of the next block.
- R9: The remaining length drops by the page size after each page. The loader finishes as soon as it is zero or negative, so at least one page is always copied. When it finishes it issues no further operations or writes.
- R10: `done` stays high until the next `start`. A start taken while idle or done clears `done` and `bad_blocks`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (taken when idle or done) |
| page_large | input | 1 | 1 selects 2048-byte pages, 0 selects 512 |
| block_bytes | input | 32 | Erase block size in bytes |
| image_bytes | input | 32 | Image length in bytes |
| dest_base | input | 32 | Destination byte address of the first page |
| op_req | output | 1 | Operation request, held until `op_done` |
| op_kind | output | 2 | 0 command, 1 address, 2 page transfer |
| op_byte | output | 8 | Command or address byte |
| op_spare | output | 1 | Transfer covers the spare area only |
| op_done | input | 1 | One-cycle completion pulse from the engine |
| buf_spare | output | 1 | Buffer read selects the spare area |
| buf_word | output | 7 | Buffer word index |
| buf_rdata | input | 32 | Buffer word, one cycle after the address |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | 32 | Destination byte address |
| dst_data | output | 32 | Destination write data |
| done | output | 1 | Load finished |
| bad_blocks | output | 16 | Number of blocks skipped |

## Verification
The hardest situations to reach from the ports are a bad block in the middle of a run, and an address cycle that carries the top offset bits. Both depend on what the flash holds, not on any input of the loader. The bench therefore models the flash behind the engine. It rebuilds each offset from the address bytes it receives and returns a spare mark chosen for each block. A mark with only its upper bytes set is treated as good. One scenario uses a 32 MiB block so that the second block's offset shows up in the last address cycle. The scenarios also cover an image that ends exactly on a page boundary, one that ends partway through a page, and a one-byte image.

// File: rtl/nbl_pkg.sv
`timescale 1ns/1ps
package nbl_pkg;
  localparam int OFF_W = 32;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_XFER = 2'd2
  } nbl_op_e;

  localparam logic [7:0] NCMD_RESET = 8'hFF;
  localparam logic [7:0] NCMD_SPARE = 8'h50;
  localparam logic [7:0] NCMD_MAIN  = 8'h00;
  localparam logic [7:0] GOOD_MARK  = 8'hFF;

  // Byte sent in address cycle idx for a flash byte offset.
  function automatic logic [7:0] addr_cycle(input logic [OFF_W-1:0] off,
                                            input logic [1:0] idx);
    logic [OFF_W:0] ext;
    ext = {1'b0, off};
    case (idx)
      2'd0:    return ext[7:0];
      2'd1:    return ext[16:9];
      2'd2:    return ext[24:17];
      default: return ext[32:25];
    endcase
  endfunction

  function automatic logic [OFF_W:0] take_page(input logic [OFF_W:0] remain,
                                               input logic [OFF_W-1:0] pbytes);
    return remain - {1'b0, pbytes};
  endfunction

  function automatic logic more_left(input logic [OFF_W:0] remain);
    return !remain[OFF_W] && (remain != '0);
  endfunction
endpackage

// File: rtl/nbl_offset_tracker.sv
`timescale 1ns/1ps
module nbl_offset_tracker
  import nbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             page_step,
  input  logic             blk_step,
  input  logic [OFF_W-1:0] page_bytes,
  input  logic [OFF_W-1:0] block_bytes,
  input  logic [OFF_W-1:0] image_bytes,
  input  logic [OFF_W-1:0] dest_base,
  output logic [OFF_W-1:0] cur_off,
  output logic [OFF_W-1:0] dst_page,
  output logic             more_image,
  output logic             page_room
);
  logic [OFF_W-1:0] blk_off, pg_off;
  logic [OFF_W:0]   remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_off  <= '0;
      pg_off   <= '0;
      dst_page <= '0;
      remain   <= '0;
    end else if (init) begin
      blk_off  <= '0;
      pg_off   <= '0;
      dst_page <= dest_base;
      remain   <= {1'b0, image_bytes};
    end else begin
      if (page_step) begin
        pg_off   <= pg_off + page_bytes;
        dst_page <= dst_page + page_bytes;
        remain   <= take_page(remain, page_bytes);
      end
      if (blk_step) begin
        blk_off <= blk_off + block_bytes;
        pg_off  <= '0;
      end
    end
  end

  assign cur_off    = blk_off + pg_off;
  assign more_image = more_left(remain);
  assign page_room  = pg_off < block_bytes;
endmodule

// File: rtl/nbl_copy_engine.sv
`timescale 1ns/1ps
module nbl_copy_engine #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [31:0]       dst_page,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_word,
  output logic              wr_en,
  output logic [31:0]       wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              last_wr
);
  localparam int                 WORD_BYTES = DATA_W / 8;
  localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(WORDS - 1);

  logic             active, pend;
  logic [IDX_W-1:0] idx, wr_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      pend   <= 1'b0;
      wr_idx <= '0;
    end else begin
      pend   <= active;
      wr_idx <= idx;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active) begin
        idx <= idx + 1'b1;
        if (idx == LAST_IDX) active <= 1'b0;
      end
    end
  end

  assign rd_word = idx;
  assign wr_en   = pend;
  assign wr_addr = dst_page + ({{(32-IDX_W){1'b0}}, wr_idx} * 32'(WORD_BYTES));
  assign wr_data = rd_data;
  assign last_wr = pend && (wr_idx == LAST_IDX);
endmodule

// File: rtl/nbl_ctrl_fsm.sv
`timescale 1ns/1ps
module nbl_ctrl_fsm
  import nbl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_done,
  input  logic [7:0]       spare_lo,
  input  logic             copy_last,
  input  logic             more_image,
  input  logic             page_room,
  input  logic [OFF_W-1:0] cur_off,
  output logic             op_req,
  output nbl_op_e          op_kind,
  output logic [7:0]       op_byte,
  output logic             op_spare,
  output logic             spare_rd,
  output logic             copy_go,
  output logic             page_step,
  output logic             blk_step,
  output logic             init,
  output logic             done,
  output logic             blk_bad_ev,
  output logic [CNT_W-1:0] bad_count
);
  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_SP_CMD, S_SP_ADR, S_SP_XFR, S_SP_RD, S_SP_CHK,
    S_PG_CMD, S_PG_ADR, S_PG_XFR, S_COPY, S_DECIDE, S_DONE
  } st_e;

  st_e        st, st_n;
  logic [1:0] acyc;
  logic       ack;

  assign ack = op_req && op_done;

  always_comb begin
    op_req   = 1'b0;
    op_kind  = OP_CMD;
    op_byte  = 8'h00;
    op_spare = 1'b0;
    unique case (st)
      S_RST:    begin op_req = 1'b1; op_byte = NCMD_RESET; end
      S_SP_CMD: begin op_req = 1'b1; op_byte = NCMD_SPARE; end
      S_PG_CMD: begin op_req = 1'b1; op_byte = NCMD_MAIN;  end
      S_SP_ADR, S_PG_ADR: begin
        op_req  = 1'b1;
        op_kind = OP_ADDR;
        op_byte = addr_cycle(cur_off, acyc);
      end
      S_SP_XFR: begin op_req = 1'b1; op_kind = OP_XFER; op_spare = 1'b1; end
      S_PG_XFR: begin op_req = 1'b1; op_kind = OP_XFER; end
      default: ;
    endcase
  end

  assign init       = start && (st == S_IDLE || st == S_DONE);
  assign blk_bad_ev = (st == S_SP_CHK) && (spare_lo != GOOD_MARK);
  assign page_step  = (st == S_COPY) && copy_last;
  assign blk_step   = blk_bad_ev || (st == S_DECIDE && more_image && !page_room);
  assign copy_go    = (st == S_PG_XFR) && ack;
  assign spare_rd   = (st == S_SP_RD);
  assign done       = (st == S_DONE);

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE, S_DONE: if (start) st_n = S_RST;
      S_RST:    if (ack) st_n = S_SP_CMD;
      S_SP_CMD: if (ack) st_n = S_SP_ADR;
      S_SP_ADR: if (ack && acyc == 2'd3) st_n = S_SP_XFR;
      S_SP_XFR: if (ack) st_n = S_SP_RD;
      S_SP_RD:  st_n = S_SP_CHK;
      S_SP_CHK: st_n = blk_bad_ev ? S_SP_CMD : S_PG_CMD;
      S_PG_CMD: if (ack) st_n = S_PG_ADR;
      S_PG_ADR: if (ack && acyc == 2'd3) st_n = S_PG_XFR;
      S_PG_XFR: if (ack) st_n = S_COPY;
      S_COPY:   if (copy_last) st_n = S_DECIDE;
      S_DECIDE: begin
        if (!more_image)    st_n = S_DONE;
        else if (page_room) st_n = S_PG_CMD;
        else                st_n = S_SP_CMD;
      end
      default:  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      acyc      <= 2'd0;
      bad_count <= '0;
    end else begin
      st <= st_n;
      if (ack && (st == S_SP_ADR || st == S_PG_ADR)) acyc <= acyc + 2'd1;
      if (init)            bad_count <= '0;
      else if (blk_bad_ev) bad_count <= bad_count + 1'b1;
    end
  end
endmodule

// File: rtl/nand_boot_loader.sv
`timescale 1ns/1ps
module nand_boot_loader
  import nbl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COPY_BYTES = 512,
  parameter int CNT_W      = 16,
  parameter int SMALL_PAGE = 512,
  parameter int LARGE_PAGE = 2048,
  parameter int MARK_BYTE  = 4,
  localparam int WORDS     = COPY_BYTES / (DATA_W / 8),
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              page_large,
  input  logic [31:0]       block_bytes,
  input  logic [31:0]       image_bytes,
  input  logic [31:0]       dest_base,
  output logic              op_req,
  output logic [1:0]        op_kind,
  output logic [7:0]        op_byte,
  output logic              op_spare,
  input  logic              op_done,
  output logic              buf_spare,
  output logic [IDX_W-1:0]  buf_word,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              dst_we,
  output logic [31:0]       dst_addr,
  output logic [DATA_W-1:0] dst_data,
  output logic              done,
  output logic [CNT_W-1:0]  bad_blocks
);
  localparam logic [IDX_W-1:0] MARK_WORD = IDX_W'(MARK_BYTE / (DATA_W / 8));

  logic [31:0]      page_bytes, cur_off, dst_page;
  logic             more_image, page_room;
  logic             spare_rd, copy_go, page_step, blk_step, init;
  logic             blk_bad_ev, page_end_ev;
  logic [IDX_W-1:0] copy_word;
  nbl_op_e          kind_e;

  assign page_bytes = page_large ? 32'(LARGE_PAGE) : 32'(SMALL_PAGE);

  nbl_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .op_done(op_done),
    .spare_lo(buf_rdata[7:0]), .copy_last(page_end_ev),
    .more_image(more_image), .page_room(page_room), .cur_off(cur_off),
    .op_req(op_req), .op_kind(kind_e), .op_byte(op_byte), .op_spare(op_spare),
    .spare_rd(spare_rd), .copy_go(copy_go), .page_step(page_step),
    .blk_step(blk_step), .init(init), .done(done),
    .blk_bad_ev(blk_bad_ev), .bad_count(bad_blocks)
  );

  nbl_offset_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .init(init), .page_step(page_step),
    .blk_step(blk_step), .page_bytes(page_bytes), .block_bytes(block_bytes),
    .image_bytes(image_bytes), .dest_base(dest_base), .cur_off(cur_off),
    .dst_page(dst_page), .more_image(more_image), .page_room(page_room)
  );

  nbl_copy_engine #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_copy (
    .clk(clk), .rst_n(rst_n), .go(copy_go), .dst_page(dst_page),
    .rd_data(buf_rdata), .rd_word(copy_word), .wr_en(dst_we),
    .wr_addr(dst_addr), .wr_data(dst_data), .last_wr(page_end_ev)
  );

  assign op_kind   = kind_e;
  assign buf_spare = spare_rd;
  assign buf_word  = spare_rd ? MARK_WORD : copy_word;
endmodule

// File: rtl/nbl_checker.sv
`timescale 1ns/1ps
module nbl_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             op_req,
  input logic [1:0]       op_kind,
  input logic [7:0]       op_byte,
  input logic             op_spare,
  input logic             op_done,
  input logic             dst_we,
  input logic [31:0]      dst_addr,
  input logic             done,
  input logic             blk_bad_ev,
  input logic [CNT_W-1:0] bad_blocks
);
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && !op_done |=> op_req && $stable(op_kind) && $stable(op_byte) && $stable(op_spare)); // R6
  AST_COPY_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> !op_req); // R7
  AST_WR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we && $past(dst_we) |-> dst_addr == $past(dst_addr) + 32'(DATA_W / 8)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !op_req && !dst_we); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R10
  AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_bad_ev |=> bad_blocks == $past(bad_blocks) + 1'b1); // R4
  AST_BAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_bad_ev |=> op_req && op_kind == 2'd0 && op_byte == 8'h50); // R4
endmodule

bind nand_boot_loader nbl_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_nbl_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_req(op_req), .op_kind(op_kind),
  .op_byte(op_byte), .op_spare(op_spare), .op_done(op_done), .dst_we(dst_we),
  .dst_addr(dst_addr), .done(done), .blk_bad_ev(blk_bad_ev), .bad_blocks(bad_blocks)
);

// File: tb/tb_nand_boot_loader.sv
`timescale 1ns/1ps
module tb_nand_boot_loader;
  localparam int IDX_W = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, page_large = 1'b0;
  logic [31:0] block_bytes = '0, image_bytes = '0, dest_base = '0;
  logic op_req, op_spare, op_done, buf_spare, dst_we, done;
  logic [1:0] op_kind;
  logic [7:0] op_byte;
  logic [IDX_W-1:0] buf_word;
  logic [31:0] buf_rdata, dst_addr, dst_data;
  logic [15:0] bad_blocks;

  int checks = 0, failures = 0;
  bit running = 0, reported = 0;

  always #2.5 clk = ~clk;

  nand_boot_loader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_large(page_large),
    .block_bytes(block_bytes), .image_bytes(image_bytes), .dest_base(dest_base),
    .op_req(op_req), .op_kind(op_kind), .op_byte(op_byte), .op_spare(op_spare),
    .op_done(op_done), .buf_spare(buf_spare), .buf_word(buf_word),
    .buf_rdata(buf_rdata), .dst_we(dst_we), .dst_addr(dst_addr),
    .dst_data(dst_data), .done(done), .bad_blocks(bad_blocks)
  );

  // scenario description
  int unsigned sc_mask = 0;
  logic [7:0]  sc_bad_val = 8'h00;
  int exp_op[$];
  logic [31:0] exp_wa[$], exp_wd[$];
  int exp_bad;

  function automatic int pack_op(int kind, int spare, int b);
    return kind * 512 + spare * 256 + (b & 255);
  endfunction

  function automatic logic [31:0] pat(logic [31:0] off, int k);
    return off ^ (32'(k) * 32'h9E37_79B1) ^ 32'h5A00_0000;
  endfunction

  function automatic bit is_bad(longint blk);
    return blk < 8 && sc_mask[blk[2:0]];
  endfunction

  function automatic string tag_of(int e);
    int kind = e / 512;
    int sp = (e / 256) % 2;
    int b = e % 256;
    if (kind == 1) return "R5";
    if (kind == 2) return sp ? "R3" : "R6";
    if (b == 255) return "R2";
    if (b == 8'h50) return "R3";
    return "R8";
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash and operation engine model
  logic [7:0] abyte [4];
  int acnt, dly, op_seq;
  logic [31:0] xfer_off;

  always @(posedge clk) begin
    if (!rst_n) begin
      op_done <= 1'b0; dly <= 1; acnt <= 0; op_seq <= 0; xfer_off <= '0;
      buf_rdata <= '0;
    end else begin
      if (op_done) op_done <= 1'b0;
      else if (op_req) begin
        if (dly == 0) begin op_done <= 1'b1; dly <= op_seq % 3; op_seq <= op_seq + 1; end
        else dly <= dly - 1;
      end
      if (op_req && op_done) begin
        case (op_kind)
          2'd0: acnt <= 0;
          2'd1: begin abyte[acnt % 4] <= op_byte; acnt <= acnt + 1; end
          default: xfer_off <= {24'h0, abyte[0]} | ({24'h0, abyte[1]} << 9)
                              | ({24'h0, abyte[2]} << 17) | ({24'h0, abyte[3]} << 25);
        endcase
      end
      if (buf_spare)
        buf_rdata <= (buf_word == 1)
          ? {24'hC33C5A, is_bad(longint'(xfer_off) / longint'(block_bytes)) ? sc_bad_val : 8'hFF}
          : 32'h0;
      else
        buf_rdata <= pat(xfer_off, int'(buf_word));
    end
  end

  // per-clock comparison against the expected streams
  always @(negedge clk) begin : cmp
    int got, e;
    if (rst_n && running) begin
      if (op_req && op_done) begin
        got = pack_op(int'(op_kind), int'(op_spare), int'(op_byte));
        if (exp_op.size() == 0) chk(0, "R9", got, -1);
        else begin
          e = exp_op.pop_front();
          chk(got == e, tag_of(e), got, e);
        end
      end
      if (dst_we) begin
        if (exp_wa.size() == 0) chk(0, "R9", dst_addr, -1);
        else begin
          chk(dst_addr == exp_wa.pop_front(), "R7", dst_addr, 0);
          chk(dst_data == exp_wd.pop_front(), "R7", dst_data, 0);
        end
      end
    end
  end

  task automatic push_addr(longint off);
    for (int i = 0; i < 4; i++)
      exp_op.push_back(pack_op(1, 0, int'((off >> (i == 0 ? 0 : 8 * i + 1)) & 255)));
  endtask

  task automatic run_case(bit p2k, int unsigned bb, int unsigned ib, logic [31:0] db,
                          int unsigned mask, logic [7:0] bval);
    longint remain = ib, boff, off;
    int ps = p2k ? 2048 : 512;
    longint blk = 0;
    int pg = 0;
    bit fin = 0;
    sc_mask = mask; sc_bad_val = bval; exp_bad = 0;
    exp_op.delete(); exp_wa.delete(); exp_wd.delete();
    exp_op.push_back(pack_op(0, 0, 8'hFF));
    while (!fin) begin
      boff = blk * bb;
      exp_op.push_back(pack_op(0, 0, 8'h50));
      push_addr(boff);
      exp_op.push_back(pack_op(2, 1, 0));
      if (is_bad(blk)) exp_bad++;
      else begin
        for (longint po = 0; po < bb && !fin; po += ps) begin
          off = boff + po;
          exp_op.push_back(pack_op(0, 0, 8'h00));
          push_addr(off);
          exp_op.push_back(pack_op(2, 0, 0));
          for (int k = 0; k < 128; k++) begin
            exp_wa.push_back(db + 32'(pg * ps) + 32'(4 * k));
            exp_wd.push_back(pat(32'(off), k));
          end
          pg++;
          remain -= ps;
          if (remain <= 0) fin = 1;
        end
      end
      blk++;
    end
    @(negedge clk);
    page_large = p2k; block_bytes = bb; image_bytes = ib; dest_base = db;
    start = 1'b1; running = 1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R10", done, 0);
    chk(bad_blocks == 0, "R10", bad_blocks, 0);
    while (!done) @(negedge clk);
    chk(exp_op.size() == 0, "R9", exp_op.size(), 0);
    chk(exp_wa.size() == 0, "R9", exp_wa.size(), 0);
    chk(int'(bad_blocks) == exp_bad, "R4", bad_blocks, exp_bad);
    repeat (6) @(negedge clk);
    chk(done == 1'b1, "R10", done, 1);
    chk(op_req == 1'b0 && dst_we == 1'b0, "R9", {op_req, dst_we}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=busy expected=done");
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(done == 0 && op_req == 0 && dst_we == 0, "R1", {done, op_req, dst_we}, 0);
    chk(bad_blocks == 0, "R1", bad_blocks, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 0 && op_req == 0 && dst_we == 0, "R1", {done, op_req, dst_we}, 0);
    // R8 R9: 10 pages over blocks 0 and 2, block 1 marked bad, image ends mid-page
    run_case(1'b0, 4096, 5000, 32'h1000_0000, 32'h2, 8'h00);
    // R4: two bad blocks with mark 0x7F, 2048-byte pages, exact length
    run_case(1'b1, 8192, 16384, 32'h2000_0400, 32'h5, 8'h7F);
    // R5: 32 MiB block, second block offset reaches the last address cycle
    run_case(1'b0, 32'h0200_0000, 1024, 32'h0000_8000, 32'h1, 8'hFE);
    // R9: one-byte image still copies a full page
    run_case(1'b0, 2048, 1, 32'h3000_0000, 32'h0, 8'h00);
    running = 0;
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule